// File: doc/BRIEF.md
# PWM Output Conditioning and Fault Interrupt Stage

This block sits between a set of PWM generators and the output pads. Each generator delivers a pair of PWM signals, so with the default three generators there are six lanes. Every lane has three controls: a gate that passes its PWM signal or parks it, a polarity bit that makes the pad active-low, and a fault-kill bit that decides whether the lane is forced inactive while an external fault is present. The pad stage adds no delay between a PWM signal and its pad.

The fault input is asynchronous. It passes through a flop synchronizer before it can kill a lane. The synchronized fault also sets a sticky fault flag. The flag stays set after the fault input drops and clears only on a fault-clear strobe. The generator interrupt lines and the fault flag form a raw status vector. An enable mask filters that vector into a masked view, and one interrupt line reports whether any masked bit is set.

Top module: `pwm_out_stage`

## Requirements
- R1: A lane whose enable bit is 0 drives its inactive level on its pad: 0 when its invert bit is 0, and 1 when its invert bit is 1.
- R2: An enabled, non-inverted lane that is not being killed copies its PWM input to its pad in the same cycle.
- R3: An enabled lane with its invert bit set drives the complement of its PWM input, so the pad is active-low.
- R4: While the synchronized fault is high, every lane with its fault-kill bit set drives its inactive level (its invert bit), and lanes with fault-kill clear behave as in R1 to R3.
- R5: A rise of fault_in first affects the pads after exactly two rising clock edges: after the first edge the pads are unchanged, and after the second edge killed lanes are inactive.
- R6: The fault flag (status bit NUM_GEN, bit 3 by default) becomes 1 one edge after the synchronized fault goes high. It stays 1 after fault_in drops, and it clears on the edge after fault_clr is high while the synchronized fault is low. An active fault wins over fault_clr.
- R7: Raw status bits [NUM_GEN-1:0] follow the generator interrupt inputs bit for bit, and fault_clr has no effect on them.
- R8: The masked status is the raw status ANDed with irq_en, bit for bit. irq_out is 1 exactly when some masked bit is 1.
- R9: After reset the fault flag is 0, the synchronizer is empty, and with no generator interrupt the raw status and irq_out are 0.
- R10: A fault_clr pulse while the fault flag is already 0 leaves the flag at 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pwm_in | input | 6 | PWM signals from the generators, two per generator |
| gen_irq_in | input | 3 | Interrupt level from each generator |
| fault_in | input | 1 | Asynchronous external fault, active high |
| out_en | input | 6 | Per-lane enable gate |
| out_inv | input | 6 | Per-lane polarity, 1 selects active-low |
| fault_kill | input | 6 | Per-lane kill on fault |
| irq_en | input | 4 | Status enable mask: bits 2..0 for generators, bit 3 for the fault flag |
| fault_clr | input | 1 | Clear strobe for the fault flag |
| pad_out | output | 6 | Conditioned pad levels |
| raw_status | output | 4 | Unmasked status: generator bits and the fault flag |
| masked_status | output | 4 | Status after the enable mask |
| irq_out | output | 1 | OR of the masked status bits |

## Verification
The hardest case to reach from the ports is a fault-clear strobe that arrives while the synchronized fault is still high. The set must win, and the flag must stay latched. The bench holds fault_in high until the flag has set, which takes three edges. It then pulses fault_clr and checks that the flag stays set. After that it drops fault_in, waits for the synchronizer to drain, and clears again to show that the same strobe now works. It also samples the pads between the first and second synchronizer edges to pin the two-flop latency.

// File: rtl/pwm_out_pkg.sv
package pwm_out_pkg;

   // Which fault signal forces killed lanes to their inactive level
   typedef enum logic {
      KILL_ON_LEVEL = 1'b0,   // synchronized fault level
      KILL_ON_FLAG  = 1'b1    // sticky fault flag
   } kill_src_e;

   function automatic int lanes_for(input int n_gen);
      return 2 * n_gen;
   endfunction

   function automatic int status_bits_for(input int n_gen);
      return n_gen + 1;
   endfunction

endpackage

// File: rtl/pwm_out_sync.sv
module pwm_out_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("pwm_out_sync needs at least two stages");
      end
   endgenerate

   logic [STAGES-1:0] chain;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= '0;
      else        chain <= {chain[STAGES-2:0], d};
   end

   assign q = chain[STAGES-1];

endmodule

// File: rtl/pwm_out_lane.sv
module pwm_out_lane (
   input  logic clk,
   input  logic rst_n,
   input  logic pwm,
   input  logic en,
   input  logic inv,
   input  logic kill,
   input  logic fault_act,
   output logic pad
);

   logic gated;
   logic live;

   // The gate comes first, then the kill, then the polarity.
   // A parked or killed lane therefore shows the inactive level of its polarity.
   assign gated = pwm & en;
   assign live  = gated & ~(kill & fault_act);
   assign pad   = live ^ inv;

   assert_off_inactive_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (!en) |-> (pad == inv));

   assert_follow_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (en && !inv && !(kill && fault_act)) |-> (pad == pwm));

   assert_invert_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (en && inv && !(kill && fault_act)) |-> (pad == !pwm));

   assert_kill_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (kill && fault_act) |-> (pad == inv));

endmodule

// File: rtl/pwm_out_irq.sv
module pwm_out_irq #(
   parameter int NUM_GEN = 3,
   localparam int SW = NUM_GEN + 1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_GEN-1:0] gen_irq,
   input  logic               fault_hit,
   input  logic               clr,
   input  logic [SW-1:0]      irq_en,
   output logic [SW-1:0]      raw,
   output logic [SW-1:0]      masked,
   output logic               irq
);

   logic flag_q;

   // A fault that is still present wins over the clear strobe
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         flag_q <= 1'b0;
      else if (fault_hit) flag_q <= 1'b1;
      else if (clr)       flag_q <= 1'b0;
   end

   assign raw    = {flag_q, gen_irq};
   assign masked = raw & irq_en;
   assign irq    = |masked;

   assert_flag_set_R6: assert property (@(posedge clk) disable iff (!rst_n)
      fault_hit |=> raw[NUM_GEN]);

   assert_flag_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (raw[NUM_GEN] && !clr) |=> raw[NUM_GEN]);

   assert_flag_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (clr && !fault_hit) |=> !raw[NUM_GEN]);

   assert_gen_raw_R7: assert property (@(posedge clk) disable iff (!rst_n)
      raw[NUM_GEN-1:0] == gen_irq);

   assert_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (masked == '0) |-> !irq);

   assert_mask_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (masked & ~irq_en) == '0);

endmodule

// File: rtl/pwm_out_stage.sv
module pwm_out_stage
   import pwm_out_pkg::*;
#(
   parameter int        NUM_GEN     = 3,
   parameter int        SYNC_STAGES = 2,
   parameter kill_src_e KILL_SRC    = KILL_ON_LEVEL,
   localparam int       NOUT        = 2 * NUM_GEN,
   localparam int       SW          = NUM_GEN + 1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NOUT-1:0]    pwm_in,
   input  logic [NUM_GEN-1:0] gen_irq_in,
   input  logic               fault_in,
   input  logic [NOUT-1:0]    out_en,
   input  logic [NOUT-1:0]    out_inv,
   input  logic [NOUT-1:0]    fault_kill,
   input  logic [SW-1:0]      irq_en,
   input  logic               fault_clr,
   output logic [NOUT-1:0]    pad_out,
   output logic [SW-1:0]      raw_status,
   output logic [SW-1:0]      masked_status,
   output logic               irq_out
);

   generate
      if (NUM_GEN < 1) begin : g_bad_gen
         $error("pwm_out_stage needs at least one generator");
      end
      if (NOUT != lanes_for(NUM_GEN) || SW != status_bits_for(NUM_GEN)) begin : g_bad_derive
         $error("pwm_out_stage derived widths disagree");
      end
   endgenerate

   logic fault_sync;
   logic kill_act;

   pwm_out_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (fault_in),
      .q     (fault_sync)
   );

   pwm_out_irq #(.NUM_GEN(NUM_GEN)) u_irq (
      .clk       (clk),
      .rst_n     (rst_n),
      .gen_irq   (gen_irq_in),
      .fault_hit (fault_sync),
      .clr       (fault_clr),
      .irq_en    (irq_en),
      .raw       (raw_status),
      .masked    (masked_status),
      .irq       (irq_out)
   );

   generate
      if (KILL_SRC == KILL_ON_FLAG) begin : g_kill_flag
         assign kill_act = raw_status[NUM_GEN];
      end else begin : g_kill_level
         assign kill_act = fault_sync;
      end
   endgenerate

   for (genvar i = 0; i < NOUT; i++) begin : g_lane
      pwm_out_lane u_lane (
         .clk       (clk),
         .rst_n     (rst_n),
         .pwm       (pwm_in[i]),
         .en        (out_en[i]),
         .inv       (out_inv[i]),
         .kill      (fault_kill[i]),
         .fault_act (kill_act),
         .pad       (pad_out[i])
      );
   end

   // The sticky flag can never be set while the synchronizer is empty from reset
   assert_flag_after_sync_R5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(raw_status[NUM_GEN]) |-> $past(fault_sync));

endmodule

// File: tb/sim_pwm_out_stage.sv
module sim_pwm_out_stage;

   localparam int NG = 3;
   localparam int NO = 6;
   localparam int SW = 4;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [NO-1:0] pwm_in = '0;
   logic [NG-1:0] gen_irq_in = '0;
   logic          fault_in = 1'b0;
   logic [NO-1:0] out_en = '0;
   logic [NO-1:0] out_inv = '0;
   logic [NO-1:0] fault_kill = '0;
   logic [SW-1:0] irq_en = '0;
   logic          fault_clr = 1'b0;
   logic [NO-1:0] pad_out;
   logic [SW-1:0] raw_status;
   logic [SW-1:0] masked_status;
   logic          irq_out;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   pwm_out_stage u0 (
      .clk           (clk),
      .rst_n         (rst_n),
      .pwm_in        (pwm_in),
      .gen_irq_in    (gen_irq_in),
      .fault_in      (fault_in),
      .out_en        (out_en),
      .out_inv       (out_inv),
      .fault_kill    (fault_kill),
      .irq_en        (irq_en),
      .fault_clr     (fault_clr),
      .pad_out       (pad_out),
      .raw_status    (raw_status),
      .masked_status (masked_status),
      .irq_out       (irq_out)
   );

   // Each row: {enable, invert, pwm, expected pad}, no fault present
   localparam int NV = 7;
   localparam logic [23:0] VEC [NV] = '{
      {6'h3F, 6'h00, 6'h2A, 6'h2A},   // R2 follow
      {6'h3F, 6'h3F, 6'h2A, 6'h15},   // R3 active-low
      {6'h00, 6'h00, 6'h3F, 6'h00},   // R1 parked low
      {6'h00, 6'h3F, 6'h15, 6'h3F},   // R1 parked high
      {6'h0F, 6'h30, 6'h3F, 6'h3F},   // R1 R2 mix
      {6'h33, 6'h05, 6'h21, 6'h24},   // R1 R2 R3 mix
      {6'h3C, 6'h0C, 6'h18, 6'h14}    // R1 R3 mix
   };

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
   endtask

   task automatic cyc(input int n);
      for (int k = 0; k < n; k++) @(negedge clk);
   endtask

   initial begin
      #(20000 * 5);
      if (!done) begin
         errors++;
         $display("FAIL watchdog: actual hung expected finish");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      cyc(3);
      rst_n = 1'b1;
      cyc(1);
      chk("R9 raw status after reset", raw_status, 4'h0);
      chk("R9 irq after reset", irq_out, 1'b0);

      // Table walk
      for (int v = 0; v < NV; v++) begin
         out_en  = VEC[v][23:18];
         out_inv = VEC[v][17:12];
         pwm_in  = VEC[v][11:6];
         fault_kill = 6'h3F;         // kill enabled but no fault: no effect
         #1;
         chk($sformatf("R1 R2 R3 table row %0d", v), pad_out, VEC[v][5:0]);
         cyc(1);
      end

      // Fault path and latency
      out_en = 6'h3F; out_inv = 6'h00; pwm_in = 6'h3F; fault_kill = 6'h0F; irq_en = 4'h0;
      cyc(1);
      fault_in = 1'b1;
      cyc(1);
      chk("R5 pads unchanged after one edge", pad_out, 6'h3F);
      cyc(1);
      chk("R4 R5 killed lanes after two edges", pad_out, 6'h30);
      chk("R6 flag not yet set", raw_status[3], 1'b0);
      cyc(1);
      chk("R6 flag set", raw_status[3], 1'b1);
      out_inv = 6'h01;
      #1;
      chk("R4 killed inverted lane is high", pad_out, 6'h31);
      out_inv = 6'h00;

      // Clear while the fault is still present: the set wins
      fault_clr = 1'b1;
      cyc(1);
      fault_clr = 1'b0;
      cyc(1);
      chk("R6 set wins over clear", raw_status[3], 1'b1);

      fault_in = 1'b0;
      cyc(4);
      chk("R6 flag held after fault drop", raw_status[3], 1'b1);
      chk("R4 pads restored", pad_out, 6'h3F);
      chk("R8 masked fault off", masked_status, 4'h0);
      chk("R8 irq off when masked", irq_out, 1'b0);
      irq_en = 4'h8;
      #1;
      chk("R8 masked fault on", masked_status, 4'h8);
      chk("R8 irq from fault", irq_out, 1'b1);

      fault_clr = 1'b1;
      cyc(1);
      fault_clr = 1'b0;
      chk("R6 flag cleared", raw_status[3], 1'b0);
      chk("R8 irq drops after clear", irq_out, 1'b0);

      fault_clr = 1'b1;
      cyc(1);
      fault_clr = 1'b0;
      chk("R10 clear with no flag", raw_status[3], 1'b0);

      // Generator interrupts
      gen_irq_in = 3'h5; irq_en = 4'h0;
      #1;
      chk("R7 raw generator bits", raw_status, 4'h5);
      chk("R8 all masked", irq_out, 1'b0);
      irq_en = 4'h2;
      #1;
      chk("R8 mask misses", masked_status, 4'h0);
      chk("R8 irq still off", irq_out, 1'b0);
      irq_en = 4'h4;
      #1;
      chk("R8 masked generator bit", masked_status, 4'h4);
      chk("R8 irq from generator", irq_out, 1'b1);
      fault_clr = 1'b1;
      cyc(1);
      fault_clr = 1'b0;
      cyc(1);
      chk("R7 clear leaves generator bits", raw_status, 4'h5);

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule